// File: doc/BRIEF.md
# Dual-Mode Prioritized Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised number of peripheral sources, plus one non-maskable input. It selects at most one request and hands it to the CPU. A hand-off can happen only on a cycle where the CPU marks an instruction boundary. The controller then stays busy until the CPU reports that its exception entry is complete. With each hand-off it presents the vector number and the mask values the CPU should load.

A run-time mode field chooses between two schemes. In the simple scheme, a single CPU mask bit blocks every maskable source, and the sources are ranked by index. In the multi-level scheme, each source carries a programmable 3-bit priority that is compared with the CPU's 3-bit mask level. In this scheme, equal priorities fall back to the index ranking. The non-maskable input is edge-detected and held pending until it is taken. It outranks everything in both schemes.

Top module: `dual_mode_intc`

## Requirements
- R1: After reset, `irq_take`, `irq_vec`, `irq_new_imask` and `irq_new_ilevel` are all zero.
- R2: A source whose `src_en` bit is 0 is never accepted, whatever its `src_req`.
- R3: With `cfg_mode` = 0 (simple scheme, `cfg_mode[1]`=0), the pending enabled source with the lowest index wins, and its vector is `VEC_BASE` + index.
- R4: In the simple scheme, `cpu_imask`=1 blocks every maskable source. A blocked request is accepted later, once the mask is cleared, while the request is still held.
- R5: A source accepted in the simple scheme reports `irq_new_imask`=1, and `irq_new_ilevel` equal to the current `cpu_ilevel`.
- R6: With `cfg_mode` = 2 (multi-level scheme, `cfg_mode[1]`=1), the eligible source with the highest priority wins. Source i's priority is `src_prio[3*i+2:3*i]`. `irq_new_ilevel` reports that priority, and `irq_new_imask` echoes `cpu_imask`.
- R7: In the multi-level scheme, a source is eligible only if its priority is strictly above `cpu_ilevel`. The one exception is priority 7, which is eligible even at level 7.
- R8: In the multi-level scheme, among sources of equal priority the lower index wins.
- R9: A rising edge on `nmi_in` is held pending and wins over all sources in both schemes, regardless of either mask. It yields vector `VEC_NMI`, `irq_new_imask`=1 and `irq_new_ilevel`=7. A level that stays high does not trigger a second acceptance.
- R10: Acceptance happens only on a cycle with `insn_boundary`=1. `irq_take` pulses for one cycle, on the clock edge that samples that boundary.
- R11: After an acceptance, no further acceptance occurs until `exc_done` has been seen.
- R12: In the multi-level scheme, `cpu_imask` has no effect on eligibility.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | 0 = simple scheme, 2 = multi-level scheme (bit 1 decides) |
| src_req | input | NSRC | Source request levels |
| src_en | input | NSRC | Per-source enables |
| src_prio | input | 3*NSRC | Per-source 3-bit priorities |
| nmi_in | input | 1 | Non-maskable request, edge-detected |
| cpu_imask | input | 1 | CPU single mask bit |
| cpu_ilevel | input | 3 | CPU 3-bit mask level |
| insn_boundary | input | 1 | Instruction boundary strobe |
| exc_done | input | 1 | CPU has completed exception entry |
| irq_take | output | 1 | One-cycle acceptance pulse |
| irq_vec | output | VW | Accepted vector number |
| irq_new_imask | output | 1 | Mask bit for the CPU to load |
| irq_new_ilevel | output | 3 | Mask level for the CPU to load |

## Verification
All results are registered once, so `irq_take` and its vector and mask values appear on the edge that samples `insn_boundary`. The bench raises the strobe at a falling edge, lowers it at the next falling edge and reads the outputs there, which is one edge after the stimulus. An edge on `nmi_in` needs one additional edge to become pending. The bench therefore applies it a full cycle before the boundary. Negative checks, such as a masked, disabled or low-priority source, or a busy controller, read `irq_take` at the same falling edge. They are followed by a positive acceptance, which shows that the request was held rather than dropped.

// File: rtl/dual_mode_intc.sv
module dual_mode_intc #(
  parameter int NSRC     = 8,
  parameter int VW       = 8,
  parameter int VEC_BASE = 32,
  parameter int VEC_NMI  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NSRC-1:0]   src_en,
  input  logic [3*NSRC-1:0] src_prio,
  input  logic              nmi_in,
  input  logic              cpu_imask,
  input  logic [2:0]        cpu_ilevel,
  input  logic              insn_boundary,
  input  logic              exc_done,
  output logic              irq_take,
  output logic [VW-1:0]     irq_vec,
  output logic              irq_new_imask,
  output logic [2:0]        irq_new_ilevel
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic            multi;
  logic [2:0]      pr [NSRC];
  logic [NSRC-1:0] elig;
  logic            hit;
  logic [IW-1:0]   win;
  logic [2:0]      wprio;
  logic            nmi_q, nmi_pend, busy, fire;

  assign multi = cfg_mode[1];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign pr[g]   = multi ? src_prio[3*g +: 3] : 3'd0;
    assign elig[g] = src_req[g] & src_en[g] &
                     (multi ? ((pr[g] > cpu_ilevel) || (pr[g] == 3'd7)) : !cpu_imask);
  end

  always_comb begin
    hit   = 1'b0;
    win   = '0;
    wprio = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (elig[i] && (!hit || pr[i] >= wprio)) begin
        hit   = 1'b1;
        win   = IW'(i);
        wprio = pr[i];
      end
    end
  end

  assign fire = insn_boundary && !busy && (nmi_pend || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q          <= 1'b0;
      nmi_pend       <= 1'b0;
      busy           <= 1'b0;
      irq_take       <= 1'b0;
      irq_vec        <= '0;
      irq_new_imask  <= 1'b0;
      irq_new_ilevel <= 3'd0;
    end else begin
      nmi_q    <= nmi_in;
      irq_take <= fire;
      if (nmi_in && !nmi_q)       nmi_pend <= 1'b1;
      else if (fire && nmi_pend)  nmi_pend <= 1'b0;
      if (exc_done) busy <= 1'b0;
      if (fire) begin
        busy <= 1'b1;
        if (nmi_pend) begin
          irq_vec        <= VW'(VEC_NMI);
          irq_new_imask  <= 1'b1;
          irq_new_ilevel <= 3'd7;
        end else begin
          irq_vec        <= VW'(VEC_BASE) + VW'(win);
          irq_new_imask  <= multi ? cpu_imask : 1'b1;
          irq_new_ilevel <= multi ? wprio : cpu_ilevel;
        end
      end
    end
  end

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(insn_boundary)); // R10
  AST_TAKE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take); // R11
  AST_SIMPLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !$past(nmi_pend) && !$past(cfg_mode[1])) |-> !$past(cpu_imask)); // R4
  AST_LEVEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !$past(nmi_pend) && $past(cfg_mode[1])) |->
      (irq_new_ilevel > $past(cpu_ilevel) || irq_new_ilevel == 3'd7)); // R7
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && $past(nmi_pend)) |-> (irq_vec == VW'(VEC_NMI) && irq_new_ilevel == 3'd7)); // R9
endmodule

// File: tb/dual_mode_intc_test.sv
`timescale 1ns/1ps
module dual_mode_intc_test;
  localparam int NSRC = 8, VW = 8, VB = 32, VN = 7;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0;
  logic [NSRC-1:0] src_req = 0, src_en = 0;
  logic [3*NSRC-1:0] src_prio = 0;
  logic nmi_in = 0, cpu_imask = 0, insn_boundary = 0, exc_done = 0;
  logic [2:0] cpu_ilevel = 0;
  logic irq_take, irq_new_imask;
  logic [VW-1:0] irq_vec;
  logic [2:0] irq_new_ilevel;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  dual_mode_intc #(.NSRC(NSRC), .VW(VW), .VEC_BASE(VB), .VEC_NMI(VN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .src_req(src_req), .src_en(src_en),
    .src_prio(src_prio), .nmi_in(nmi_in), .cpu_imask(cpu_imask), .cpu_ilevel(cpu_ilevel),
    .insn_boundary(insn_boundary), .exc_done(exc_done), .irq_take(irq_take), .irq_vec(irq_vec),
    .irq_new_imask(irq_new_imask), .irq_new_ilevel(irq_new_ilevel));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic pulse;
    @(negedge clk) insn_boundary = 1;
    @(negedge clk) insn_boundary = 0;
  endtask

  task automatic complete;
    @(negedge clk) exc_done = 1;
    @(negedge clk) exc_done = 0;
  endtask

  task automatic clr;
    @(negedge clk);
    src_req = 0; src_en = 0; src_prio = 0; cpu_imask = 0; cpu_ilevel = 0; cfg_mode = 0;
  endtask

  task automatic set_prio(input int idx, input logic [2:0] p);
    src_prio[3*idx +: 3] = p;
  endtask

  task automatic t_reset;
    expect_eq("R1 take", irq_take, 0);
    expect_eq("R1 vec", irq_vec, 0);
    expect_eq("R1 imask", irq_new_imask, 0);
    expect_eq("R1 ilevel", irq_new_ilevel, 0);
  endtask

  task automatic t_enable;
    clr; src_req[3] = 1;
    pulse; expect_eq("R2 disabled source taken", irq_take, 0);
  endtask

  task automatic t_boundary;
    clr; src_req[2] = 1; src_en[2] = 1;
    repeat (3) begin @(negedge clk); expect_eq("R10 take without boundary", irq_take, 0); end
    pulse;
    expect_eq("R10 take at boundary", irq_take, 1);
    expect_eq("R10 vec", irq_vec, VB+2);
    @(negedge clk); expect_eq("R10 take one cycle", irq_take, 0);
    complete;
  endtask

  task automatic t_rank;
    clr; src_req = 8'b0010_0100; src_en = 8'hFF; cpu_ilevel = 4;
    pulse;
    expect_eq("R3 lowest index wins", irq_vec, VB+2);
    expect_eq("R5 imask set", irq_new_imask, 1);
    expect_eq("R5 ilevel kept", irq_new_ilevel, 4);
    complete;
  endtask

  task automatic t_mask;
    clr; src_req[6] = 1; src_en[6] = 1; cpu_imask = 1;
    pulse; expect_eq("R4 masked taken", irq_take, 0);
    cpu_imask = 0;
    pulse;
    expect_eq("R4 held request taken", irq_take, 1);
    expect_eq("R4 vec", irq_vec, VB+6);
    complete;
  endtask

  task automatic t_busy;
    clr; src_req[1] = 1; src_en[1] = 1;
    pulse; expect_eq("R11 first take", irq_take, 1);
    pulse; expect_eq("R11 take while busy", irq_take, 0);
    complete;
    pulse; expect_eq("R11 take after done", irq_take, 1);
    complete;
  endtask

  task automatic t_prio;
    clr; cfg_mode = 2; cpu_imask = 1; cpu_ilevel = 2;
    set_prio(1, 3); set_prio(4, 6); src_req = 8'b0001_0010; src_en = 8'hFF;
    pulse;
    expect_eq("R12 imask ignored in multi-level", irq_take, 1);
    expect_eq("R6 highest priority vec", irq_vec, VB+4);
    expect_eq("R6 new ilevel", irq_new_ilevel, 6);
    expect_eq("R6 imask echoed", irq_new_imask, 1);
    complete;
  endtask

  task automatic t_level;
    clr; cfg_mode = 2; cpu_ilevel = 5; set_prio(1, 5); src_req[1] = 1; src_en[1] = 1;
    pulse; expect_eq("R7 equal level taken", irq_take, 0);
    set_prio(1, 7); cpu_ilevel = 7;
    pulse;
    expect_eq("R7 level 7 accepted at mask 7", irq_take, 1);
    expect_eq("R7 vec", irq_vec, VB+1);
    expect_eq("R7 ilevel", irq_new_ilevel, 7);
    complete;
  endtask

  task automatic t_tie;
    clr; cfg_mode = 2; set_prio(3, 4); set_prio(6, 4); set_prio(0, 2);
    src_req = 8'b0100_1001; src_en = 8'hFF;
    pulse;
    expect_eq("R8 tie lower index", irq_vec, VB+3);
    complete;
  endtask

  task automatic t_nmi;
    clr; cpu_imask = 1; src_req[2] = 1; src_en[2] = 1;
    nmi_in = 1;
    @(negedge clk);
    pulse;
    expect_eq("R9 nmi taken under mask", irq_take, 1);
    expect_eq("R9 nmi vec", irq_vec, VN);
    expect_eq("R9 nmi imask", irq_new_imask, 1);
    expect_eq("R9 nmi ilevel", irq_new_ilevel, 7);
    complete;
    pulse; expect_eq("R9 held level no retrigger", irq_take, 0);
    nmi_in = 0;
    clr; cfg_mode = 2; cpu_ilevel = 0; set_prio(7, 7); src_req[7] = 1; src_en[7] = 1;
    nmi_in = 1;
    @(negedge clk);
    pulse;
    expect_eq("R9 nmi beats prio 7", irq_vec, VN);
    complete;
    nmi_in = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_enable;
    t_boundary;
    t_rank;
    t_mask;
    t_busy;
    t_prio;
    t_level;
    t_tie;
    t_nmi;
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule